// File: doc/BRIEF.md
# Oversampled Bit-Clock and Data Recovery Loop

This block regenerates the bit clock for a one-bit demodulated receive line and turns that line into NRZI-decoded data words. The line is first brought into the clock domain through a short flip-flop chain. It is then sampled several times in each bit period. In the triple mode there are three samples per bit, and in the double mode there are two. The spacing between samples comes from a reload counter counted in units of `UNIT_CLKS` system clocks.

One sample in each bit is the decision sample. On that sample only, the next reload value is lengthened or shortened by one unit, depending on where the most recent line transitions fell. This pulls the sampling grid toward the centre of each bit. Every sample pushes a transition flag into a history register, and that register is also brought out for an external carrier-detect circuit.

Each decision sample yields one decoded bit: 1 when the line has not changed since the previous decision, 0 when it has. The decoded bits collect in a word register that holds a sentinel bit. Each time a full word has arrived, the register delivers it with a one-cycle strobe. A signed counter tallies the phase corrections for debug.

Top module: `bitrec_dpll`

## Requirements
- R1: While and right after `rst`, `word_valid` is 0, `trans_hist` is all zeros and `corr_count` is 0; the first sample is taken `NOM_A*UNIT_CLKS` clocks after reset is released.
- R2: Every sample shifts one flag into `trans_hist` at bit 0 (newest) and moves older flags up by one; the flag is 1 when the sample differs from the previous sample (0 after reset) and 0 otherwise.
- R3: With `two_per_bit`=0 the phase runs 0,1,2,0,… with phase 0 as the decision sample; samples are `NOM_A` (4) units apart unless a correction applies, so a bit without corrections lasts 12 units.
- R4: With `two_per_bit`=1 the phase alternates 0,1 with phase 0 as the decision sample; samples are `NOM_B` (6) units apart unless a correction applies.
- R5: In triple mode, a decision sample that leaves the three newest history bits at binary 001 (transition seen on this sample only) makes the next interval 5 units and adds 1 to `corr_count`.
- R6: In triple mode, a decision sample that leaves the three newest history bits at binary 100 (transition seen two samples back) makes the next interval 3 units and subtracts 1 from `corr_count`; every other pattern keeps 4 units.
- R7: In double mode, the two newest history bits at 01 on a decision sample give a 7-unit interval and +1, 10 gives 5 units and -1, anything else 6 units; samples other than the decision sample never adjust the interval.
- R8: The decoded bit is 1 when the decision sample equals the value stored at the previous decision, else 0; the stored value is 0 after reset and is refreshed on every decision.
- R9: Decoded bits enter a 17-bit register from the top; the first decoded bit of a word ends up in `word_data` bit 0, and `word_valid` pulses for exactly one cycle, in the cycle after the decision that completes 16 bits.
- R10: `rx_line` passes through a two-flop synchronizer, and NRZI data whose bit rate is 2% above or below nominal is recovered bit for bit in both modes.
- R11: `corr_count` is a signed two's-complement count that saturates at its limits and changes only on decision samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous demodulated receive line |
| two_per_bit | input | 1 | 0: three samples per bit; 1: two samples per bit |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | WORD_W | Decoded word, first bit received in bit 0 |
| trans_hist | output | HIST_W | Transition history, bit 0 is the newest sample |
| corr_count | output | CORR_W | Signed net count of late minus early corrections |

## Verification
A wrong reload value or phase count shows up at the ports within one word. The spacing between two `word_valid` strobes on an idle line moves away from 768 clocks, and that spacing moves by exactly one unit after a single placed edge. A mis-shifted history register shows within one sample interval, because `trans_hist` is probed at points between samples after a lone edge. A flaw in decoding or packing shows in the very next word, since one toggle after idle must read 0xFFFE. Weak phase tracking shows as a missing payload and a wrongly signed `corr_count` after a few hundred bits at ±2% rate offset.

// File: rtl/bitrec_pkg.sv
package bitrec_pkg;

   // outcome of the early/late judgement on a decision sample
   typedef enum logic [1:0] {
      PH_HOLD  = 2'd0,
      PH_LATE  = 2'd1,
      PH_EARLY = 2'd2
   } ph_adj_e;

   // h[0] is the newest transition flag
   function automatic ph_adj_e judge(input logic two_per_bit, input logic [2:0] h);
      ph_adj_e r;
      r = PH_HOLD;
      if (two_per_bit) begin
         case (h[1:0])
            2'b01:   r = PH_LATE;
            2'b10:   r = PH_EARLY;
            default: r = PH_HOLD;
         endcase
      end else begin
         case (h)
            3'b001:  r = PH_LATE;
            3'b100:  r = PH_EARLY;
            default: r = PH_HOLD;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/bitrec_sync.sv
module bitrec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bitrec_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bitrec_edge_hist.sv
module bitrec_edge_hist #(
   parameter int HIST_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              smp,
   output logic [HIST_W-1:0] hist_now,
   output logic [HIST_W-1:0] hist_next
);
   logic prev;
   logic trans;

   always_comb begin
      trans     = smp ^ prev;
      hist_next = {hist_now[HIST_W-2:0], trans};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev     <= 1'b0;
         hist_now <= '0;
      end else if (tick) begin
         prev     <= smp;
         hist_now <= hist_next;
      end
   end

   // R2: older flags move up by one place on every sample
   a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
      tick |=> (hist_now[HIST_W-1:1] == $past(hist_now[HIST_W-2:0])));

   // R2: history only moves on a sample
   a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(hist_now));
endmodule

// File: rtl/bitrec_timer.sv
module bitrec_timer
   import bitrec_pkg::*;
#(
   parameter int UNIT_CLKS = 4,
   parameter int NOM_A     = 4,
   parameter int NOM_B     = 6,
   parameter int CORR_W    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              two_per_bit,
   input  logic [2:0]        hist_low,
   output logic              tick,
   output logic              decide,
   output logic [CORR_W-1:0] corr_count
);
   localparam int MAX_U   = ((NOM_A > NOM_B) ? NOM_A : NOM_B) + 1;
   localparam int CNT_W   = $clog2(MAX_U * UNIT_CLKS);
   localparam logic [CNT_W-1:0]  START = CNT_W'(NOM_A * UNIT_CLKS - 1);
   localparam logic [CORR_W-1:0] C_MAX = {1'b0, {(CORR_W-1){1'b1}}};
   localparam logic [CORR_W-1:0] C_MIN = {1'b1, {(CORR_W-1){1'b0}}};

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;
   logic [1:0]       phase;
   logic [1:0]       last_ph;
   ph_adj_e          adj;
   int               units;

   always_comb begin
      last_ph = two_per_bit ? 2'd1 : 2'd2;
      tick    = (cnt == '0);
      decide  = tick && (phase == 2'd0);
      adj     = decide ? judge(two_per_bit, hist_low) : PH_HOLD;
      units   = two_per_bit ? NOM_B : NOM_A;
      case (adj)
         PH_LATE:  units = units + 1;
         PH_EARLY: units = units - 1;
         default:  units = units;
      endcase
      reload = CNT_W'(units * UNIT_CLKS - 1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt        <= START;
         phase      <= 2'd0;
         corr_count <= '0;
      end else if (tick) begin
         cnt   <= reload;
         phase <= (phase >= last_ph) ? 2'd0 : phase + 2'd1;
         case (adj)
            PH_LATE:  if (corr_count != C_MAX) corr_count <= corr_count + 1'b1;
            PH_EARLY: if (corr_count != C_MIN) corr_count <= corr_count - 1'b1;
            default:  corr_count <= corr_count;
         endcase
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   // R3: triple mode phase returns to the decision sample after phase 2
   a_r3_phase_wrap: assert property (@(posedge clk) disable iff (rst)
      (tick && !two_per_bit && phase == 2'd2) |=> (phase == 2'd0));

   // R4: double mode phase alternates
   a_r4_phase_alt: assert property (@(posedge clk) disable iff (rst)
      (tick && two_per_bit && phase == 2'd1) |=> (phase == 2'd0));

   // R11: the debug count moves only on a decision sample
   a_r11_hold_off_decision: assert property (@(posedge clk) disable iff (rst)
      !decide |=> $stable(corr_count));
endmodule

// File: rtl/bitrec_packer.sv
module bitrec_packer #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              decide,
   input  logic              smp,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data
);
   localparam logic [WORD_W:0] EMPTY = {1'b1, {WORD_W{1'b0}}};

   logic            last_dec;
   logic            bit_val;
   logic [WORD_W:0] acc;
   logic [WORD_W:0] nxt;

   always_comb begin
      bit_val = (smp == last_dec);
      nxt     = {bit_val, acc[WORD_W:1]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_dec   <= 1'b0;
         acc        <= EMPTY;
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= 1'b0;
         if (decide) begin
            last_dec <= smp;
            if (nxt[0]) begin
               word_data  <= nxt[WORD_W:1];
               word_valid <= 1'b1;
               acc        <= EMPTY;
            end else begin
               acc <= nxt;
            end
         end
      end
   end

   // R9: strobe lasts a single cycle
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> !word_valid);

   // R9: a word only follows a decision sample
   a_r9_after_decide: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> $past(decide));
endmodule

// File: rtl/bitrec_dpll.sv
module bitrec_dpll #(
   parameter int UNIT_CLKS   = 4,
   parameter int NOM_A       = 4,
   parameter int NOM_B       = 6,
   parameter int SYNC_STAGES = 2,
   parameter int HIST_W      = 32,
   parameter int WORD_W      = 16,
   parameter int CORR_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_line,
   input  logic              two_per_bit,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic [HIST_W-1:0] trans_hist,
   output logic [CORR_W-1:0] corr_count
);
   generate
      if (HIST_W < 3)    begin : g_bad_hist  $error("bitrec_dpll: HIST_W below 3");  end
      if (NOM_A < 2)     begin : g_bad_noma  $error("bitrec_dpll: NOM_A below 2");   end
      if (NOM_B < 2)     begin : g_bad_nomb  $error("bitrec_dpll: NOM_B below 2");   end
      if (UNIT_CLKS < 1) begin : g_bad_unit  $error("bitrec_dpll: UNIT_CLKS below 1"); end
      if (WORD_W < 1)    begin : g_bad_word  $error("bitrec_dpll: WORD_W below 1");  end
      if (CORR_W < 2)    begin : g_bad_corr  $error("bitrec_dpll: CORR_W below 2");  end
   endgenerate

   logic              smp;
   logic              tick;
   logic              decide;
   logic [HIST_W-1:0] hist_next;

   bitrec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (rx_line),
      .q   (smp)
   );

   bitrec_edge_hist #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .smp       (smp),
      .hist_now  (trans_hist),
      .hist_next (hist_next)
   );

   bitrec_timer #(
      .UNIT_CLKS (UNIT_CLKS),
      .NOM_A     (NOM_A),
      .NOM_B     (NOM_B),
      .CORR_W    (CORR_W)
   ) u_timer (
      .clk         (clk),
      .rst         (rst),
      .two_per_bit (two_per_bit),
      .hist_low    (hist_next[2:0]),
      .tick        (tick),
      .decide      (decide),
      .corr_count  (corr_count)
   );

   bitrec_packer #(.WORD_W(WORD_W)) u_pack (
      .clk        (clk),
      .rst        (rst),
      .decide     (decide),
      .smp        (smp),
      .word_valid (word_valid),
      .word_data  (word_data)
   );
endmodule

// File: tb/bitrec_dpll_test.sv
`timescale 1ns/1ps
module bitrec_dpll_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rx_line = 1'b0;
   logic        two_per_bit = 1'b0;
   logic        word_valid;
   logic [15:0] word_data;
   logic [31:0] trans_hist;
   logic [15:0] corr_count;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;
   bit  collect = 0;
   bit  rxb [2048];
   int  rx_n = 0;
   bit  pay [256];

   always #5 clk = ~clk;

   bitrec_dpll uut (
      .clk (clk), .rst (rst), .rx_line (rx_line), .two_per_bit (two_per_bit),
      .word_valid (word_valid), .word_data (word_data),
      .trans_hist (trans_hist), .corr_count (corr_count)
   );

   always @(negedge clk) begin
      if (collect && word_valid) begin
         for (int k = 0; k < 16; k++) begin
            if (rx_n < 2048) begin
               rxb[rx_n] = word_data[k];
               rx_n++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input bit mode, input bit level);
      rst = 1'b1;
      rx_line = level;
      two_per_bit = mode;
      repeat (5) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_word();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!word_valid && n < 4000);
      chk(word_valid, "R9", "word strobe seen", word_valid, 1);
   endtask

   // counts clocks from one strobe to the next, optionally toggling the line
   task automatic measure(input int change_at, input int p1_at, input int p2_at,
                          output int gap, output logic [31:0] p1, output logic [31:0] p2);
      int n = 0;
      p1 = '0;
      p2 = '0;
      do begin
         @(negedge clk);
         n++;
         if (n == change_at) rx_line = ~rx_line;
         if (n == p1_at) p1 = trans_hist;
         if (n == p2_at) p2 = trans_hist;
      end while (!word_valid && n < 4000);
      gap = n;
   endtask

   task automatic t_reset_idle(input bit mode);
      int gap;
      logic [31:0] p1, p2;
      do_reset(mode, 1'b0);
      chk(word_valid == 1'b0, "R1", "strobe after reset", word_valid, 0);
      chk(trans_hist == '0, "R1", "history after reset", trans_hist, 0);
      chk(corr_count == '0, "R1", "count after reset", corr_count, 0);
      wait_word();
      chk(word_data == 16'hFFFF, "R8", "idle first word", word_data, 16'hFFFF);
      measure(-1, -1, -1, gap, p1, p2);
      chk(gap == 768, mode ? "R4" : "R3", "nominal word spacing", gap, 768);
      chk(word_data == 16'hFFFF, "R9", "idle second word", word_data, 16'hFFFF);
   endtask

   task automatic t_edge(input bit mode, input bit early);
      int gap;
      int ch;
      int exp_gap;
      logic [31:0] p1, p2;
      do_reset(mode, 1'b0);
      wait_word();
      if (!mode) ch = early ? 5 : 38;
      else       ch = early ? 5 : 30;
      exp_gap = early ? 764 : 772;
      if (!mode && early) measure(ch, 20, 36, gap, p1, p2);
      else if (mode && early) measure(ch, 30, 40, gap, p1, p2);
      else measure(ch, 50, -1, gap, p1, p2);
      if (!mode && early) begin
         chk(p1 == 32'h1, "R2 R3", "flag after first sample", p1, 1);
         chk(p2 == 32'h2, "R2 R3", "flag after second sample", p2, 2);
      end else if (mode && early) begin
         chk(p1 == 32'h1, "R2 R4", "flag after first sample", p1, 1);
         chk(p2 == 32'h1, "R2 R4", "no sample within 6 units", p2, 1);
      end else begin
         chk(p1 == 32'h1, "R2", "flag after decision sample", p1, 1);
      end
      chk(gap == exp_gap, mode ? "R7" : (early ? "R6" : "R5"), "corrected spacing", gap, exp_gap);
      chk(word_data == 16'hFFFE, "R8", "one toggle decodes to 0 in bit 0", word_data, 16'hFFFE);
      chk($signed(corr_count) == (early ? -1 : 1), "R11", "correction count",
          $signed(corr_count), early ? -1 : 1);
   endtask

   task automatic t_reset_high();
      do_reset(1'b0, 1'b1);
      wait_word();
      chk(word_data == 16'hFFFE, "R8", "reference starts at 0", word_data, 16'hFFFE);
      chk($signed(corr_count) == 1, "R5", "first sample sees edge late", $signed(corr_count), 1);
   endtask

   task automatic t_stream(input bit mode, input bit slow, input logic [15:0] seed);
      real per;
      logic [15:0] lf;
      int ones;
      bit found;
      bit b;
      per = slow ? 489.6 : 470.4;
      do_reset(mode, 1'b0);
      rx_n = 0;
      collect = 1;
      lf = seed;
      ones = 0;
      for (int i = 0; i < 256; i++) begin
         b = lf[0];
         lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
         if (ones == 3) b = 1'b0;
         ones = b ? ones + 1 : 0;
         pay[i] = b;
      end
      for (int i = 0; i < 48; i++) begin
         rx_line = ~rx_line;
         #(per);
      end
      for (int i = 0; i < 256; i++) begin
         if (!pay[i]) rx_line = ~rx_line;
         #(per);
      end
      for (int i = 0; i < 32; i++) begin
         rx_line = ~rx_line;
         #(per);
      end
      repeat (200) @(negedge clk);
      collect = 0;
      found = 0;
      for (int s = 0; s + 256 <= rx_n; s++) begin
         bit m = 1;
         for (int j = 0; j < 256; j++) if (rxb[s + j] != pay[j]) m = 0;
         if (m) found = 1;
      end
      chk(found, "R10", "payload recovered at rate offset", found, 1);
      if (slow)
         chk($signed(corr_count) > 0, "R11", "net late corrections for slow data", $signed(corr_count), 1);
      else
         chk($signed(corr_count) < 0, "R11", "net early corrections for fast data", $signed(corr_count), -1);
   endtask

   initial begin
      t_reset_idle(1'b0);
      t_reset_idle(1'b1);
      t_edge(1'b0, 1'b0);
      t_edge(1'b0, 1'b1);
      t_edge(1'b1, 1'b0);
      t_edge(1'b1, 1'b1);
      t_reset_high();
      t_stream(1'b0, 1'b1, 16'hACE1);
      t_stream(1'b0, 1'b0, 16'h1D2B);
      t_stream(1'b1, 1'b1, 16'h7F31);
      t_stream(1'b1, 1'b0, 16'h5A0F);
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(1_900_000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule